// File: doc/BRIEF.md
# Packet Transfer Timeout and Spill Controller

This block guards one outgoing path of a packet switch against a transfer that stalls or runs too slowly. It follows the character stream from a source port to the set of destinations chosen for the current packet. One of these destinations may be the internal configuration port. While doing so it runs a down-counter loaded from a programmable value. When that counter runs out, the block takes over the source: it drains and discards every remaining character up to the packet's end marker. It also raises a request to every destination of the packet to append an error end-of-packet marker.

The same block is placed on every source, including the configuration port when that port sends a reply. A slow command sender is therefore cut off by its own timer, and a reply that stalls is cut off by the configuration port's timer. Under multicast distribution the block waits without any limit while every destination is running but one of them is still busy. Once characters flow, each transmitted character restarts the count.

Top module: `pkt_spill_ctrl`

## Requirements
- R1: A packet-start strobe is taken only while the block is idle. At that strobe it latches the destination mask and loads the counter with the reload value. A start strobe that arrives while a packet is active or spilling has no effect on that packet's timing or on its destination mask.
- R2: While a packet is active and counting is allowed, the counter decreases by one per cycle. Expiry is decided in the counting cycle that finds the counter at zero. Spill and timeout outputs assert on the following clock edge. With reload value R, spill_o rises after the (R+1)-th counting cycle. A reload value of 0 expires on the first counting cycle.
- R3: While tmr_en_i is low, the counter keeps its value and no expiry occurs. Counting resumes from the held value when tmr_en_i returns high.
- R4: With dist_en_i high, before the first character of the packet has moved, the counter is held when every masked destination is running and at least one masked destination is busy. If a masked destination is not running, or if dist_en_i is low, the counter runs while the packet waits.
- R5: Every char_xfer_i strobe during an active packet reloads the counter. A strobe in the same cycle as the counter reaches zero prevents expiry.
- R6: A char_xfer_i strobe with src_eop_i high ends the packet and returns the block to idle without a spill. This also holds in the cycle in which expiry would otherwise have occurred.
- R7: On expiry, timeout_o is high for exactly one cycle, spill_o rises, and eep_req_o sets the bit of every destination in the latched mask. Bit N_DST-1 is the configuration port.
- R8: spill_o stays high, and char_xfer_i is ignored, until a cycle with src_valid_i and src_eop_i both high. spill_o is low from the next cycle on.
- R9: Each eep_req_o bit stays high until a cycle in which its eep_ack_i bit is high, and is low from the next cycle on. If a new expiry sets the bit in the same cycle as its acknowledge, the bit stays high.
- R10: While rst_ni is low, spill_o, timeout_o and eep_req_o are all zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_en_i | input | 1 | Allows the timeout counter to decrement |
| dist_en_i | input | 1 | Multicast distribution mode; enables the busy hold-off |
| reload_i | input | TMR_W | Counter reload value |
| pkt_start_i | input | 1 | Header accepted; a new packet begins |
| dst_mask_i | input | N_DST | Destinations of the new packet, sampled with pkt_start_i |
| dst_busy_i | input | N_DST | Per-destination busy status |
| dst_run_i | input | N_DST | Per-destination running status |
| char_xfer_i | input | 1 | One character moved from source to destinations |
| src_valid_i | input | 1 | Source has a character available |
| src_eop_i | input | 1 | The source character is an end marker (normal or error) |
| eep_ack_i | input | N_DST | Destination has appended its error end marker |
| spill_o | output | 1 | Drain and discard the source |
| timeout_o | output | 1 | One-cycle expiry pulse |
| eep_req_o | output | N_DST | Per-destination request to append an error end marker |

## Verification
Two pairs of functions can meet in one cycle. The first is counter expiry with a character transfer, plain or carrying the end marker. The second is a fresh expiry setting an EEP request with that destination's acknowledge. The bench provokes both by counting cycles from the start strobe to the edge at which the counter reaches zero, and by placing the strobe or acknowledge exactly on that edge. Expected outcomes: the character wins and no spill starts, and a set request survives the acknowledge. These are judged by directed checks and by the cycle-accurate reference model.

// File: rtl/spill_pkg.sv
package spill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_XFER  = 2'd2,
    ST_SPILL = 2'd3
  } spill_st_e;
endpackage

// File: rtl/spill_timer.sv
module spill_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             count_i,
  input  logic [TMR_W-1:0] reload_i,
  output logic             expire_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= reload_i;
    else if (count_i && !cnt_zero) cnt_q <= cnt_q - 1'b1;
  end

  // a reload in the same cycle always beats expiry
  assign expire_o = count_i && !load_i && cnt_zero;
endmodule

// File: rtl/spill_fsm.sv
module spill_fsm
  import spill_pkg::*;
#(
  parameter int N_DST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmr_en_i,
  input  logic             dist_en_i,
  input  logic             pkt_start_i,
  input  logic [N_DST-1:0] dst_mask_i,
  input  logic [N_DST-1:0] dst_busy_i,
  input  logic [N_DST-1:0] dst_run_i,
  input  logic             char_xfer_i,
  input  logic             src_valid_i,
  input  logic             src_eop_i,
  input  logic             expire_i,
  output logic             load_o,
  output logic             count_o,
  output logic [N_DST-1:0] eep_set_o,
  output logic             spill_o,
  output logic             timeout_o
);
  spill_st_e        st_q, st_d;
  logic [N_DST-1:0] mask_q;
  logic             to_q;
  logic             active;
  logic             all_run;
  logic             any_busy;
  logic             hold;
  logic             fire;

  assign active   = (st_q == ST_WAIT) || (st_q == ST_XFER);
  assign all_run  = &(dst_run_i | ~mask_q);
  assign any_busy = |(dst_busy_i & mask_q);
  // multicast wait on busy but live destinations is unbounded
  assign hold     = (st_q == ST_WAIT) && dist_en_i && all_run && any_busy;

  assign load_o  = ((st_q == ST_IDLE) && pkt_start_i) || (active && char_xfer_i);
  assign count_o = active && tmr_en_i && !hold;
  assign fire    = active && expire_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (pkt_start_i) st_d = ST_WAIT;
      ST_WAIT, ST_XFER: begin
        if (char_xfer_i) st_d = src_eop_i ? ST_IDLE : ST_XFER;
        else if (fire)   st_d = ST_SPILL;
      end
      ST_SPILL: if (src_valid_i && src_eop_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      to_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      to_q <= fire;
      if ((st_q == ST_IDLE) && pkt_start_i) mask_q <= dst_mask_i;
    end
  end

  assign eep_set_o = fire ? mask_q : '0;
  assign spill_o   = (st_q == ST_SPILL);
  assign timeout_o = to_q;
endmodule

// File: rtl/eep_req_bank.sv
module eep_req_bank #(
  parameter int N_DST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DST-1:0] set_i,
  input  logic [N_DST-1:0] ack_i,
  output logic [N_DST-1:0] req_o
);
  for (genvar g = 0; g < N_DST; g++) begin : g_req
    logic req_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       req_q <= 1'b0;
      else if (set_i[g]) req_q <= 1'b1;
      else if (ack_i[g]) req_q <= 1'b0;
    end
    assign req_o[g] = req_q;
  end
endmodule

// File: rtl/pkt_spill_ctrl.sv
module pkt_spill_ctrl #(
  parameter int N_DST = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmr_en_i,
  input  logic             dist_en_i,
  input  logic [TMR_W-1:0] reload_i,
  input  logic             pkt_start_i,
  input  logic [N_DST-1:0] dst_mask_i,
  input  logic [N_DST-1:0] dst_busy_i,
  input  logic [N_DST-1:0] dst_run_i,
  input  logic             char_xfer_i,
  input  logic             src_valid_i,
  input  logic             src_eop_i,
  input  logic [N_DST-1:0] eep_ack_i,
  output logic             spill_o,
  output logic             timeout_o,
  output logic [N_DST-1:0] eep_req_o
);
  logic             tmr_load;
  logic             tmr_count;
  logic             tmr_expire;
  logic [N_DST-1:0] eep_set;

  spill_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .count_i  (tmr_count),
    .reload_i (reload_i),
    .expire_o (tmr_expire)
  );

  spill_fsm #(.N_DST(N_DST)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmr_en_i    (tmr_en_i),
    .dist_en_i   (dist_en_i),
    .pkt_start_i (pkt_start_i),
    .dst_mask_i  (dst_mask_i),
    .dst_busy_i  (dst_busy_i),
    .dst_run_i   (dst_run_i),
    .char_xfer_i (char_xfer_i),
    .src_valid_i (src_valid_i),
    .src_eop_i   (src_eop_i),
    .expire_i    (tmr_expire),
    .load_o      (tmr_load),
    .count_o     (tmr_count),
    .eep_set_o   (eep_set),
    .spill_o     (spill_o),
    .timeout_o   (timeout_o)
  );

  eep_req_bank #(.N_DST(N_DST)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (eep_set),
    .ack_i  (eep_ack_i),
    .req_o  (eep_req_o)
  );
endmodule

// File: rtl/pkt_spill_ctrl_chk.sv
module pkt_spill_ctrl_chk #(
  parameter int N_DST = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tmr_en_i,
  input logic             char_xfer_i,
  input logic             src_valid_i,
  input logic             src_eop_i,
  input logic [N_DST-1:0] eep_ack_i,
  input logic             spill_o,
  input logic             timeout_o,
  input logic [N_DST-1:0] eep_req_o
);
  AST_TO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R7

  AST_TO_WITH_SPILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> spill_o); // R7

  AST_NO_TO_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_en_i |=> !timeout_o); // R3

  AST_NO_TO_ON_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_xfer_i && !spill_o) |=> !timeout_o); // R5

  AST_SPILL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_o && !(src_valid_i && src_eop_i)) |=> spill_o); // R8

  AST_SPILL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_o && src_valid_i && src_eop_i) |=> !spill_o); // R8

  for (genvar g = 0; g < N_DST; g++) begin : g_chk
    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eep_req_o[g] && !eep_ack_i[g]) |=> eep_req_o[g]); // R9
    AST_REQ_RISE_ON_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(eep_req_o[g]) |-> timeout_o); // R7
  end
endmodule

bind pkt_spill_ctrl pkt_spill_ctrl_chk #(.N_DST(N_DST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tmr_en_i    (tmr_en_i),
  .char_xfer_i (char_xfer_i),
  .src_valid_i (src_valid_i),
  .src_eop_i   (src_eop_i),
  .eep_ack_i   (eep_ack_i),
  .spill_o     (spill_o),
  .timeout_o   (timeout_o),
  .eep_req_o   (eep_req_o)
);

// File: tb/pkt_spill_ctrl_tb.sv
module pkt_spill_ctrl_tb;
  localparam int N = 4;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tmr_en = 1'b0, dist_en = 1'b0;
  logic [TW-1:0] reload = '0;
  logic          pkt_start = 1'b0;
  logic [N-1:0]  dst_mask = '0, dst_busy = '0, dst_run = '1, eep_ack = '0;
  logic          char_xfer = 1'b0, src_valid = 1'b0, src_eop = 1'b0;
  logic          spill, tmo;
  logic [N-1:0]  eep_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  pkt_spill_ctrl #(.N_DST(N), .TMR_W(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_en_i(tmr_en), .dist_en_i(dist_en),
    .reload_i(reload), .pkt_start_i(pkt_start), .dst_mask_i(dst_mask),
    .dst_busy_i(dst_busy), .dst_run_i(dst_run), .char_xfer_i(char_xfer),
    .src_valid_i(src_valid), .src_eop_i(src_eop), .eep_ack_i(eep_ack),
    .spill_o(spill), .timeout_o(tmo), .eep_req_o(eep_req)
  );

  // behavioural reference: 0 idle, 1 waiting, 2 moving, 3 spilling
  int            m_state;
  int            m_cnt;
  logic [N-1:0]  m_mask, m_req;
  logic          m_to;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_mask = '0; m_req = '0; m_to = 1'b0;
    end else begin
      logic [N-1:0] set_v;
      bit           held;
      set_v = '0;
      m_to  = 1'b0;
      case (m_state)
        0: if (pkt_start) begin
             m_mask = dst_mask; m_cnt = int'(reload); m_state = 1;
           end
        1, 2: begin
          held = (m_state == 1) && dist_en && ((dst_run | ~m_mask) == '1)
                 && ((dst_busy & m_mask) != '0);
          if (char_xfer) begin
            m_cnt = int'(reload);
            m_state = src_eop ? 0 : 2;
          end else if (tmr_en && !held) begin
            if (m_cnt == 0) begin
              m_state = 3; m_to = 1'b1; set_v = m_mask;
            end else m_cnt = m_cnt - 1;
          end
        end
        default: if (src_valid && src_eop) m_state = 0;
      endcase
      m_req = (m_req & ~eep_ack) | set_v;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(spill === (m_state == 3), "R8 spill_o model", int'(spill), int'(m_state == 3));
      chk(tmo === m_to, "R7 timeout_o model", int'(tmo), int'(m_to));
      chk(eep_req === m_req, "R9 eep_req_o model", int'(eep_req), int'(m_req));
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input logic [N-1:0] m);
    pkt_start = 1'b1; dst_mask = m;
    cyc(1);
    pkt_start = 1'b0; dst_mask = '0;
  endtask

  task automatic end_spill();
    src_valid = 1'b1; src_eop = 1'b1;
    cyc(1);
    src_valid = 1'b0; src_eop = 1'b0;
  endtask

  task automatic ack_all();
    eep_ack = '1;
    cyc(1);
    eep_ack = '0;
  endtask

  initial begin
    cyc(3);
    chk(spill == 1'b0 && tmo == 1'b0 && eep_req == '0, "R10 reset outputs",
        int'({spill, tmo, eep_req}), 0);
    rst_n = 1'b1;
    tmr_en = 1'b1; reload = 16'd5;
    cyc(1);

    // basic expiry with configuration port in the mask
    do_start(4'b1001);
    cyc(5); chk(spill == 1'b0, "R2 no spill before R+1 cycles", int'(spill), 0);
    cyc(1); chk(spill == 1'b1, "R2 spill after R+1 cycles", int'(spill), 1);
    chk(tmo == 1'b1, "R7 timeout pulse", int'(tmo), 1);
    chk(eep_req == 4'b1001, "R7 requests to masked ports", int'(eep_req), 9);
    cyc(1); chk(tmo == 1'b0, "R7 timeout one cycle", int'(tmo), 0);
    char_xfer = 1'b1; cyc(1); char_xfer = 1'b0;
    chk(spill == 1'b1, "R8 char ignored in spill", int'(spill), 1);
    end_spill();
    chk(spill == 1'b0, "R8 spill ends at end marker", int'(spill), 0);
    chk(eep_req == 4'b1001, "R9 requests held", int'(eep_req), 9);
    eep_ack = 4'b0001; cyc(1); eep_ack = '0;
    chk(eep_req == 4'b1000, "R9 ack clears one bit", int'(eep_req), 8);
    eep_ack = 4'b1000; cyc(1); eep_ack = '0;

    // timer disabled
    tmr_en = 1'b0;
    do_start(4'b0010);
    cyc(20); chk(spill == 1'b0, "R3 no expiry while disabled", int'(spill), 0);
    tmr_en = 1'b1;
    cyc(5); chk(spill == 1'b0, "R3 count resumes from held value", int'(spill), 0);
    cyc(1); chk(spill == 1'b1, "R3 expiry after resume", int'(spill), 1);
    end_spill(); ack_all();

    // multicast hold-off on busy, running destinations
    dist_en = 1'b1; dst_busy = 4'b0001;
    do_start(4'b0011);
    cyc(20); chk(spill == 1'b0, "R4 busy wait unbounded", int'(spill), 0);
    dst_busy = '0;
    cyc(5); chk(spill == 1'b0, "R4 count after busy clears", int'(spill), 0);
    cyc(1); chk(spill == 1'b1, "R4 expiry after busy clears", int'(spill), 1);
    end_spill(); ack_all();

    dst_run = 4'b1110; dst_busy = 4'b0001;
    do_start(4'b0011);
    cyc(6); chk(spill == 1'b1, "R4 timer runs if a port is down", int'(spill), 1);
    end_spill(); ack_all();
    dst_run = '1;

    dist_en = 1'b0;
    do_start(4'b0011);
    cyc(6); chk(spill == 1'b1, "R4 busy timed without distribution", int'(spill), 1);
    end_spill(); ack_all();
    dst_busy = '0;

    // characters keep reloading
    do_start(4'b0100);
    for (int i = 0; i < 8; i++) begin
      cyc(3); char_xfer = 1'b1; cyc(1); char_xfer = 1'b0;
    end
    chk(spill == 1'b0, "R5 steady characters avoid expiry", int'(spill), 0);
    cyc(5); char_xfer = 1'b1; cyc(1); char_xfer = 1'b0;
    chk(spill == 1'b0 && tmo == 1'b0, "R5 char wins at zero", int'(spill), 0);
    char_xfer = 1'b1; src_eop = 1'b1; cyc(1); char_xfer = 1'b0; src_eop = 1'b0;
    cyc(20); chk(spill == 1'b0, "R6 idle after end marker", int'(spill), 0);

    do_start(4'b0100);
    cyc(5); char_xfer = 1'b1; src_eop = 1'b1; cyc(1); char_xfer = 1'b0; src_eop = 1'b0;
    chk(spill == 1'b0, "R6 end marker at expiry cycle", int'(spill), 0);
    cyc(10); chk(spill == 1'b0 && eep_req == '0, "R6 no spill later", int'(spill), 0);

    // second start while active is ignored
    do_start(4'b0001);
    pkt_start = 1'b1; dst_mask = 4'b1100; cyc(1); pkt_start = 1'b0; dst_mask = '0;
    cyc(4); chk(spill == 1'b0, "R1 restart ignored, no early spill", int'(spill), 0);
    cyc(1); chk(spill == 1'b1, "R1 timing from first start", int'(spill), 1);
    chk(eep_req == 4'b0001, "R1 first mask kept", int'(eep_req), 1);
    end_spill();

    // set and ack collide on a pending bit
    do_start(4'b0001);
    cyc(5); eep_ack = 4'b0001; cyc(1); eep_ack = '0;
    chk(eep_req == 4'b0001, "R9 set wins over ack", int'(eep_req), 1);
    end_spill(); ack_all();
    chk(eep_req == '0, "R9 cleared by ack", int'(eep_req), 0);

    // zero reload
    reload = '0;
    do_start(4'b1000);
    cyc(1); chk(spill == 1'b1 && tmo == 1'b1, "R2 zero reload expires at once", int'(spill), 1);
    end_spill(); ack_all();
    cyc(3);
    finish_run();
  end
endmodule